// File: doc/BRIEF.md
# ICOUNT Fetch Thread Selector

This block decides, every cycle, which hardware thread of a simultaneous multithreading core may fetch. It tracks, for each of up to eight threads, how many of that thread's instructions are in flight in the back end. Fetch goes to the eligible thread with the fewest such instructions, so each thread's share of back-end resources stays roughly even. A thread is switched on or off with its enable bit alone; no context-switch sequence is needed.

Each thread has a static occupancy cap. A thread that has reached its cap is skipped, so a stalled thread cannot take over the shared back end. When exactly one thread is enabled, its cap no longer applies and it may fill the whole count range, like a single-threaded machine. A fallback mode ignores counts and caps and rotates fetch among the enabled threads, one per cycle. The grant is combinational from the current counts, the inputs and a rotation pointer. Each count moves on the clock edge by the fetch width on a grant, less that thread's commit and squash amounts for the cycle.

Top module: `smt_fetch_picker`

## Requirements
- R1: After reset every occupancy count is zero, the rotation pointer is at thread 0, and with no thread enabled the grant vector, `fetch_vld` and `fetch_pc` are all zero.
- R2: `fetch_grant` has at most one bit set, and `fetch_vld` is high exactly when one bit is set. Bit i stands for thread i.
- R3: In count mode (`rr_mode`=0), the grant goes to an eligible thread whose count is the lowest among the eligible threads. A thread is eligible when it is enabled and its count is below its cap.
- R4: Among eligible threads tied on the lowest count, the grant goes to the first one found when scanning upward with wrap-around from the rotation pointer. After every grant the pointer moves to the thread just above the granted one, wrapping from the top thread to thread 0. It does not move when there is no grant.
- R5: When two or more threads are enabled in count mode, a thread whose count is at or above its cap (`occ_cap` field i) is never granted.
- R6: When exactly one thread is enabled in count mode, its cap is ignored. That thread is granted whenever its count is below the all-ones count value (2^CW-1).
- R7: In round-robin mode (`rr_mode`=1), counts and caps are ignored. The grant goes to the first enabled thread found when scanning upward from the rotation pointer. Disabled threads are never granted in either mode.
- R8: On each clock edge, a thread's count becomes its count, plus FW if the thread is granted this cycle, minus its commit amount, minus its squash amount. The result is clamped below at zero and above at 2^CW-1. This applies whether or not the thread is enabled.
- R9: When no thread is eligible, `fetch_grant` is zero, `fetch_vld` is low and `fetch_pc` is zero.
- R10: When a thread is granted, `fetch_pc` equals that thread's field of `thr_pc` (bits i*PCW upward).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | NTHR | Per-thread enable |
| rr_mode | input | 1 | 1 selects round-robin fallback, 0 selects count-based priority |
| thr_pc | input | NTHR*PCW | Per-thread program counter, thread i in field i |
| occ_cap | input | NTHR*CW | Per-thread static occupancy cap |
| commit_amt | input | NTHR*DW | Per-thread instructions committed this cycle |
| squash_amt | input | NTHR*DW | Per-thread instructions squashed this cycle |
| fetch_grant | output | NTHR | One-hot fetch grant, or zero |
| fetch_vld | output | 1 | A thread was granted this cycle |
| fetch_pc | output | PCW | Program counter of the granted thread |
| occ_cnt | output | NTHR*CW | Current per-thread in-flight counts |

## Verification
Some properties are checked on every cycle: the grant has at most one bit set and agrees with the valid flag, only enabled threads are granted, a capped thread is never granted while several threads are enabled, the PC follows the grant, and a grant with no returns raises the count by exactly the fetch width. Other behaviour appears only in the bench's scenarios: that the chosen thread really holds the lowest count, the order in which ties rotate, the solo-thread cap override, round-robin order, and clamping of the count at both ends.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    typedef enum logic {
        SEL_ICOUNT = 1'b0,
        SEL_RR     = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/icnt_occ_ctr.sv
module icnt_occ_ctr #(
    parameter int CW = 6,
    parameter int DW = 3,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_i,
    input  logic [DW-1:0] commit_i,
    input  logic [DW-1:0] squash_i,
    output logic [CW-1:0] cnt_o
);
    localparam int SW = ((CW > DW) ? CW : DW) + 2;
    localparam logic [CW-1:0] MAXC = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_q, st_d;
    logic [SW-1:0] up_s, dn_s, net_s;

    always_comb begin
        st_d  = st_q;
        up_s  = SW'(st_q.cnt) + (grant_i ? SW'(FW) : '0);
        dn_s  = SW'(commit_i) + SW'(squash_i);
        net_s = (up_s > dn_s) ? (up_s - dn_s) : '0;
        if (net_s > SW'(MAXC)) begin
            net_s = SW'(MAXC);
        end
        st_d.cnt = net_s[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_INC_BY_FW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(grant_i) && $past(commit_i) == '0 && $past(squash_i) == '0
         && $past(cnt_o) <= (MAXC - CW'(FW)))
        |-> cnt_o == $past(cnt_o) + CW'(FW)); // R8

endmodule

// File: rtl/icnt_pick.sv
module icnt_pick
    import icnt_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int CW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sel_mode_e            mode_i,
    input  logic [NTHR-1:0]      active_i,
    input  logic [NTHR*CW-1:0]   cap_i,
    input  logic [NTHR*CW-1:0]   cnt_i,
    output logic [NTHR-1:0]      grant_o,
    output logic                 vld_o
);
    localparam int PW = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam logic [CW-1:0] MAXC = '1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } pick_t;

    pick_t st_q, st_d;

    logic [CW-1:0] cnt_a [NTHR];
    logic [CW-1:0] cap_a [NTHR];
    logic [NTHR-1:0] elig;
    logic [PW:0]   nact;
    logic          solo;
    logic          found;
    logic [PW-1:0] best_idx;
    logic [CW-1:0] best_cnt;
    logic [PW:0]   idx;

    for (genvar g = 0; g < NTHR; g++) begin : g_unpack
        assign cnt_a[g] = cnt_i[g*CW +: CW];
        assign cap_a[g] = cap_i[g*CW +: CW];
    end

    always_comb begin
        nact = '0;
        for (int k = 0; k < NTHR; k++) begin
            nact = nact + (PW+1)'(active_i[k]);
        end
        solo = (nact == (PW+1)'(1));
        for (int k = 0; k < NTHR; k++) begin
            if (mode_i == SEL_RR) begin
                elig[k] = active_i[k];
            end else begin
                elig[k] = active_i[k] && (cnt_a[k] < (solo ? MAXC : cap_a[k]));
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        found    = 1'b0;
        best_idx = '0;
        best_cnt = MAXC;
        idx      = '0;
        for (int k = 0; k < NTHR; k++) begin
            idx = (PW+1)'(st_q.ptr) + (PW+1)'(k);
            if (idx >= (PW+1)'(NTHR)) begin
                idx = idx - (PW+1)'(NTHR);
            end
            if (elig[idx[PW-1:0]] &&
                (!found || (mode_i == SEL_ICOUNT && cnt_a[idx[PW-1:0]] < best_cnt))) begin
                found    = 1'b1;
                best_idx = idx[PW-1:0];
                best_cnt = cnt_a[idx[PW-1:0]];
            end
        end
        grant_o = '0;
        if (found) begin
            grant_o[best_idx] = 1'b1;
            st_d.ptr = (best_idx == PW'(NTHR-1)) ? '0 : best_idx + 1'b1;
        end
        vld_o = found;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R2
    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == ($countones(grant_o) == 1)); // R2

    for (genvar g = 0; g < NTHR; g++) begin : g_chk
        AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[g] |-> active_i[g]); // R7
        AST_CAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[g] && mode_i == SEL_ICOUNT && $countones(active_i) > 1)
            |-> cnt_a[g] < cap_a[g]); // R5
    end

endmodule

// File: rtl/smt_fetch_picker.sv
module smt_fetch_picker
    import icnt_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int CW   = 6,
    parameter int DW   = 3,
    parameter int FW   = 4,
    parameter int PCW  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTHR-1:0]      thr_en,
    input  logic                 rr_mode,
    input  logic [NTHR*PCW-1:0]  thr_pc,
    input  logic [NTHR*CW-1:0]   occ_cap,
    input  logic [NTHR*DW-1:0]   commit_amt,
    input  logic [NTHR*DW-1:0]   squash_amt,
    output logic [NTHR-1:0]      fetch_grant,
    output logic                 fetch_vld,
    output logic [PCW-1:0]       fetch_pc,
    output logic [NTHR*CW-1:0]   occ_cnt
);
    sel_mode_e mode;
    assign mode = rr_mode ? SEL_RR : SEL_ICOUNT;

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        icnt_occ_ctr #(
            .CW (CW),
            .DW (DW),
            .FW (FW)
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant_i  (fetch_grant[g]),
            .commit_i (commit_amt[g*DW +: DW]),
            .squash_i (squash_amt[g*DW +: DW]),
            .cnt_o    (occ_cnt[g*CW +: CW])
        );
    end

    icnt_pick #(
        .NTHR (NTHR),
        .CW   (CW)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .active_i (thr_en),
        .cap_i    (occ_cap),
        .cnt_i    (occ_cnt),
        .grant_o  (fetch_grant),
        .vld_o    (fetch_vld)
    );

    always_comb begin
        fetch_pc = '0;
        for (int k = 0; k < NTHR; k++) begin
            fetch_pc = fetch_pc | (fetch_grant[k] ? thr_pc[k*PCW +: PCW] : '0);
        end
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_pcchk
        AST_PC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_grant[g] |-> fetch_pc == thr_pc[g*PCW +: PCW]); // R10
    end

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_en == '0) |-> (!fetch_vld && fetch_pc == '0)); // R9

endmodule

// File: tb/sim_smt_fetch_picker.sv
`timescale 1ns/1ps
module sim_smt_fetch_picker;
    localparam int N   = 4;
    localparam int CW  = 5;
    localparam int DW  = 3;
    localparam int FW  = 2;
    localparam int PCW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     thr_en = '0;
    logic             rr_mode = 1'b0;
    logic [N*PCW-1:0] thr_pc;
    logic [N*CW-1:0]  occ_cap;
    logic [N*DW-1:0]  commit_amt = '0;
    logic [N*DW-1:0]  squash_amt = '0;
    logic [N-1:0]     fetch_grant;
    logic             fetch_vld;
    logic [PCW-1:0]   fetch_pc;
    logic [N*CW-1:0]  occ_cnt;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    smt_fetch_picker #(.NTHR(N), .CW(CW), .DW(DW), .FW(FW), .PCW(PCW)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .rr_mode(rr_mode),
        .thr_pc(thr_pc), .occ_cap(occ_cap), .commit_amt(commit_amt),
        .squash_amt(squash_amt), .fetch_grant(fetch_grant),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .occ_cnt(occ_cnt)
    );

    // vector fields: [11:8] enables, [7] round-robin, [6:4] commit for all, [3:0] expected grant
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        12'b1111_0_000_0001,  // R3 R4 all zero, pointer at 0
        12'b1111_0_000_0010,  // R4
        12'b1111_0_000_0100,  // R4
        12'b1111_0_000_1000,  // R4
        12'b1111_0_000_0001,  // R4 wrap
        12'b1111_0_000_0010,  // R3
        12'b0011_0_000_0001,  // R3 two active
        12'b0011_0_000_0010,  // R5 thread0 at cap
        12'b0011_0_000_0000,  // R5 R9 both capped
        12'b0011_1_000_0001,  // R7 caps ignored
        12'b0011_1_000_0010,  // R7
        12'b0001_0_000_0001,  // R6 solo above cap
        12'b1111_0_000_0100,  // R3 R4 tie from pointer
        12'b1111_0_111_1000,  // R3 lowest, then commits
        12'b1111_0_000_0100   // R8 floor, R4 tie
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        thr_en = '0;
        rr_mode = 1'b0;
        commit_amt = '0;
        squash_amt = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [PCW-1:0] pc_of(input logic [N-1:0] g);
        logic [PCW-1:0] r = '0;
        for (int k = 0; k < N; k++) begin
            if (g[k]) r = 32'h0000_1000 + PCW'(k) * 32'h40;
        end
        return r;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            thr_pc[k*PCW +: PCW] = 32'h0000_1000 + PCW'(k) * 32'h40;
            occ_cap[k*CW +: CW] = CW'(6);
        end
        do_reset();
        #1;
        check("R1 counts", 64'(occ_cnt), 64'd0);
        check("R1 grant", 64'(fetch_grant), 64'd0);
        check("R1 valid", 64'(fetch_vld), 64'd0);
        check("R1 pc", 64'(fetch_pc), 64'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            thr_en = VEC[v][11:8];
            rr_mode = VEC[v][7];
            for (int k = 0; k < N; k++) commit_amt[k*DW +: DW] = VEC[v][6:4];
            #1;
            check($sformatf("R3/R4/R5/R6/R7 grant vector %0d", v), 64'(fetch_grant), 64'(VEC[v][3:0]));
            check($sformatf("R2 valid vector %0d", v), 64'(fetch_vld), 64'(|VEC[v][3:0]));
            check($sformatf("R10 pc vector %0d", v), 64'(fetch_pc), 64'(pc_of(VEC[v][3:0])));
        end
        @(negedge clk);
        thr_en = '0;
        commit_amt = '0;
        #1;
        // counts after last vector: t0=3 t1=1 t2=2 t3=0
        check("R8 counts after vectors", 64'(occ_cnt), 64'({5'd0, 5'd2, 5'd1, 5'd3}));
        check("R9 none enabled grant", 64'(fetch_grant), 64'd0);
        check("R9 none enabled pc", 64'(fetch_pc), 64'd0);

        // R6 solo thread runs past its cap up to the ceiling, R8 clamps at 2^CW-1
        do_reset();
        thr_en = 4'b0001;
        for (int c = 0; c < 17; c++) begin
            #1;
            if (c == 5) check("R6 solo granted above cap", 64'(fetch_grant), 64'd1);
            @(negedge clk);
        end
        #1;
        check("R8 ceiling count", 64'(occ_cnt[CW-1:0]), 64'd31);
        check("R6 no grant at ceiling", 64'(fetch_grant), 64'd0);
        check("R9 valid low at ceiling", 64'(fetch_vld), 64'd0);

        // R8 decrement by commit and squash, disabled thread still drains
        @(negedge clk);
        thr_en = '0;
        commit_amt[DW-1:0] = 3'd3;
        squash_amt[DW-1:0] = 3'd5;
        @(negedge clk);
        #1;
        check("R8 commit plus squash", 64'(occ_cnt[CW-1:0]), 64'd23);
        commit_amt[DW-1:0] = 3'd7;
        squash_amt[DW-1:0] = 3'd7;
        @(negedge clk);
        #1;
        check("R8 large return", 64'(occ_cnt[CW-1:0]), 64'd9);
        @(negedge clk);
        #1;
        check("R8 floor at zero", 64'(occ_cnt[CW-1:0]), 64'd0);
        check("R8 other threads untouched", 64'(occ_cnt[N*CW-1:CW]), 64'd0);

        // R7 round-robin with no thread enabled grants nothing
        commit_amt = '0;
        squash_amt = '0;
        rr_mode = 1'b1;
        #1;
        check("R7 round-robin idle", 64'(fetch_vld), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule